// File: doc/BRIEF.md
# Serial Port Register Bank with Loopback

This block is the byte-wide register front end of a PC-style serial port controller, reduced to its register behaviour. A host reaches eight byte registers through single-cycle read and write strobes and a 3-bit offset. Bytes written to the data register leave on a transmit stream. Bytes arriving on a receive stream are held in a queue until the host reads them. Interrupt causes are tracked in an identification register, and a one-cycle interrupt pulse is issued for every event that raises a cause.

A loopback mode, selected by a modem control bit, sends transmitted bytes back into the receive queue and blocks the external receive stream. While it is active, the modem status register shows the modem control outputs instead of the stored line states. The baud divisor is only stored: the block has no bit-level serialisation, baud timing, parity or FIFO trigger levels.

All state changes on the rising clock edge. Read data is registered and appears on `rdata_o` in the cycle after the read strobe. The side effects of a read (popping the queue, clearing interrupt causes) take effect at the same edge.

Top module: `serial_reg_bank`

## Requirements
- R1: After reset the registers read as follows.
  - Offset 1 (interrupt enable) reads 0x00.
  - Offset 2 (interrupt identification) reads 0xC1.
  - Offset 3 (line control) reads 0x03.
  - Offset 4 (modem control) reads 0x08.
  - Offset 5 (line status) reads 0x60.
  - Offset 6 (modem status) reads 0xB0.
  - Offset 7 (scratch) reads 0x00.
  - The 16-bit divisor reads as 12.
- R2: While line control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. In that state neither the queue nor interrupt enable is touched.
- R3: A write to offset 1 (with line control bit 7 clear) keeps only bits 3:0; a read returns bits 7:4 as zero.
- R4: In normal mode (modem control bit 4 clear), a data write (offset 0, line control bit 7 clear) puts the byte on `tx_data_o` with `tx_valid_o` high for exactly the following cycle.
- R5: If interrupt enable bit 1 is set, a normal-mode data write raises the transmit cause. That cause is identification bit 1 (0x02), and raising it clears identification bit 0.
- R6: A byte accepted into the receive queue sets line status bit 0. If interrupt enable bit 0 is set, the byte also raises the receive cause, which is identification bit 2 (0x04), and clears identification bit 0.
- R7: A data read returns the oldest queued byte and removes it, and returns 0x00 when the queue is empty. Line status bit 0 clears once the queue is empty.
- R8: A data read clears the receive cause. If no cause is left, the identification register becomes 0x01.
- R9: A read of offset 2 returns the identification value ORed with 0xC0, then resets the register to 0x01.
- R10: In loopback (modem control bit 4 set), a data write goes into the receive queue and not to the transmit stream, and external receive bytes are discarded.
- R11: The receive queue holds at most 64 bytes. A push while it is full, from either source, is discarded.
- R12: In loopback, a modem status read returns bit 7 = modem control bit 3, bit 6 = bit 2, bit 5 = bit 0, bit 4 = bit 1, and the low nibble 0. Outside loopback it returns the stored 0xB0.
- R13: Line control, modem control and scratch read back the last value written. Writes to offsets 2, 5 and 6 change nothing.
- R14: `irq_o` is high for one cycle, in the cycle after an event that raises a cause. It stays low when no cause is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The hardest states to reach from the ports are the full receive queue and two interrupt causes pending at the same time.

The queue is filled past its 64-entry limit twice: once by loopback data writes and once by external receive bytes. The bench then checks that exactly the first 64 bytes come back in order and that the next read returns zero.

For the combined causes, both interrupt enables are set and a received byte is followed by a transmit write. A single data read must then leave only the transmit cause. The loopback modem status mapping is swept over all sixteen combinations of the low modem control nibble.

// File: rtl/serial_bank_pkg.sv
package serial_bank_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DATA  = 3'd0,
    OFS_IEN   = 3'd1,
    OFS_IID   = 3'd2,
    OFS_LCTL  = 3'd3,
    OFS_MCTL  = 3'd4,
    OFS_LSTAT = 3'd5,
    OFS_MSTAT = 3'd6,
    OFS_SCR   = 3'd7
  } reg_ofs_e;

  localparam logic [7:0] IID_NONE   = 8'h01;
  localparam logic [7:0] IID_TX     = 8'h02;
  localparam logic [7:0] IID_RX     = 8'h04;
  localparam logic [7:0] IID_FIXED  = 8'hC0;
  localparam logic [7:0] LCTL_RST   = 8'h03;
  localparam logic [7:0] MCTL_RST   = 8'h08;
  localparam logic [7:0] LSTAT_BASE = 8'h60;
  localparam logic [7:0] MSTAT_RST  = 8'hB0;
  localparam logic [15:0] DIV_RST   = 16'd12;

  localparam int unsigned LCTL_DIV_SEL = 7;
  localparam int unsigned MCTL_LOOP    = 4;
  localparam int unsigned IEN_RX       = 0;
  localparam int unsigned IEN_TX       = 1;
endpackage

// File: rtl/serial_rx_queue.sv
module serial_rx_queue #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              push_ok_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wr_ok, rd_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CNT_W'(DEPTH));
  assign wr_ok     = push_i && !full_o;
  assign rd_ok     = pop_i && !empty_o;
  assign push_ok_o = wr_ok;
  assign head_o    = mem_q[rptr_q];
  assign count_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ok) wptr_q <= bump(wptr_q);
      if (rd_ok) rptr_q <= bump(rptr_q);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wptr_q] <= data_i;
  end
endmodule

// File: rtl/serial_irq_ident.sv
module serial_irq_ident
  import serial_bank_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       iid_rd_i,
  input  logic       data_rd_i,
  input  logic       raise_tx_i,
  input  logic       raise_rx_i,
  output logic [7:0] iid_o,
  output logic       irq_o
);
  logic [7:0] iid_q, iid_d;
  logic       irq_q;

  // read-side clears first, then raises of this cycle
  always_comb begin
    iid_d = iid_q;
    if (iid_rd_i) iid_d = IID_NONE;
    if (data_rd_i) begin
      iid_d = iid_d & ~IID_RX;
      if (iid_d == 8'h00) iid_d = IID_NONE;
    end
    if (raise_tx_i) iid_d = (iid_d & ~IID_NONE) | IID_TX;
    if (raise_rx_i) iid_d = (iid_d & ~IID_NONE) | IID_RX;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iid_q <= IID_NONE;
      irq_q <= 1'b0;
    end else begin
      iid_q <= iid_d;
      irq_q <= raise_tx_i || raise_rx_i;
    end
  end

  assign iid_o = iid_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/serial_modem_view.sv
module serial_modem_view
  import serial_bank_pkg::*;
(
  input  logic [7:0] mctl_i,
  output logic [7:0] mstat_o
);
  logic loop;
  assign loop = mctl_i[MCTL_LOOP];

  always_comb begin
    if (loop) begin
      mstat_o = {MSTAT_RST[7:4] & 4'h0, MSTAT_RST[3:0]};
      mstat_o[7] = mctl_i[3];
      mstat_o[6] = mctl_i[2];
      mstat_o[5] = mctl_i[0];
      mstat_o[4] = mctl_i[1];
    end else begin
      mstat_o = MSTAT_RST;
    end
  end
endmodule

// File: rtl/serial_reg_bank.sv
module serial_reg_bank
  import serial_bank_pkg::*;
#(
  parameter int unsigned QUEUE_DEPTH = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  output logic       irq_o
);
  localparam int unsigned CNT_W = $clog2(QUEUE_DEPTH + 1);

  logic [3:0]  ien_q;
  logic [7:0]  lctl_q, mctl_q, scr_q;
  logic [15:0] div_q;
  logic [7:0]  rdata_q, tx_data_q;
  logic        tx_valid_q;

  logic        div_sel, loop;
  logic        wr_data, wr_ien, wr_div_lo, wr_div_hi;
  logic        rd_data, rd_iid;
  logic        q_push, q_push_ok, q_empty, q_full;
  logic [7:0]  q_din, q_head;
  logic [CNT_W-1:0] q_count;
  logic        raise_tx, raise_rx;
  logic [7:0]  iid, mstat_view, lstat, rd_val;
  reg_ofs_e    ofs;

  assign ofs     = reg_ofs_e'(addr_i);
  assign div_sel = lctl_q[LCTL_DIV_SEL];
  assign loop    = mctl_q[MCTL_LOOP];

  assign wr_data   = wr_en_i && (ofs == OFS_DATA) && !div_sel;
  assign wr_ien    = wr_en_i && (ofs == OFS_IEN)  && !div_sel;
  assign wr_div_lo = wr_en_i && (ofs == OFS_DATA) && div_sel;
  assign wr_div_hi = wr_en_i && (ofs == OFS_IEN)  && div_sel;
  assign rd_data   = rd_en_i && (ofs == OFS_DATA) && !div_sel;
  assign rd_iid    = rd_en_i && (ofs == OFS_IID);

  // loopback swaps the queue source from the RX stream to data writes
  assign q_push = loop ? wr_data : rx_valid_i;
  assign q_din  = loop ? wdata_i : rx_data_i;

  serial_rx_queue #(
    .DEPTH  (QUEUE_DEPTH),
    .DATA_W (BYTE_W)
  ) u_queue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (q_push),
    .data_i    (q_din),
    .pop_i     (rd_data),
    .head_o    (q_head),
    .empty_o   (q_empty),
    .full_o    (q_full),
    .push_ok_o (q_push_ok),
    .count_o   (q_count)
  );

  assign raise_rx = q_push_ok && ien_q[IEN_RX];
  assign raise_tx = wr_data && !loop && ien_q[IEN_TX];

  serial_irq_ident u_ident (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .iid_rd_i   (rd_iid),
    .data_rd_i  (rd_data),
    .raise_tx_i (raise_tx),
    .raise_rx_i (raise_rx),
    .iid_o      (iid),
    .irq_o      (irq_o)
  );

  serial_modem_view u_modem (
    .mctl_i  (mctl_q),
    .mstat_o (mstat_view)
  );

  assign lstat = LSTAT_BASE | {7'b0, !q_empty};

  always_comb begin
    unique case (ofs)
      OFS_DATA:  rd_val = div_sel ? div_q[7:0] : (q_empty ? 8'h00 : q_head);
      OFS_IEN:   rd_val = div_sel ? div_q[15:8] : {4'b0, ien_q};
      OFS_IID:   rd_val = iid | IID_FIXED;
      OFS_LCTL:  rd_val = lctl_q;
      OFS_MCTL:  rd_val = mctl_q;
      OFS_LSTAT: rd_val = lstat;
      OFS_MSTAT: rd_val = mstat_view;
      OFS_SCR:   rd_val = scr_q;
      default:   rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q      <= '0;
      lctl_q     <= LCTL_RST;
      mctl_q     <= MCTL_RST;
      scr_q      <= '0;
      div_q      <= DIV_RST;
      rdata_q    <= '0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      if (wr_ien)    ien_q       <= wdata_i[3:0];
      if (wr_div_lo) div_q[7:0]  <= wdata_i;
      if (wr_div_hi) div_q[15:8] <= wdata_i;
      if (wr_en_i && ofs == OFS_LCTL) lctl_q <= wdata_i;
      if (wr_en_i && ofs == OFS_MCTL) mctl_q <= wdata_i;
      if (wr_en_i && ofs == OFS_SCR)  scr_q  <= wdata_i;
      if (rd_en_i) rdata_q <= rd_val;
      tx_valid_q <= wr_data && !loop;
      if (wr_data && !loop) tx_data_q <= wdata_i;
    end
  end

  assign rdata_o    = rdata_q;
  assign tx_valid_o = tx_valid_q;
  assign tx_data_o  = tx_data_q;
endmodule

// File: rtl/serial_reg_bank_chk.sv
module serial_reg_bank_chk #(
  parameter int unsigned QUEUE_DEPTH = 64,
  parameter int unsigned CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [2:0]       addr_i,
  input logic             rx_valid_i,
  input logic [7:0]       rdata_o,
  input logic             tx_valid_o,
  input logic             irq_o,
  input logic             div_sel,
  input logic             loop,
  input logic             rd_iid,
  input logic             raise_tx,
  input logic             raise_rx,
  input logic [7:0]       iid,
  input logic [CNT_W-1:0] q_count
);
  p_ien_nibble_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_en_i && addr_i == 3'd1 && !div_sel) |-> rdata_o[7:4] == 4'h0);

  p_tx_source_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(wr_en_i && addr_i == 3'd0 && !div_sel));

  p_loop_no_tx_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !$past(loop));

  p_iid_fixed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_en_i && addr_i == 3'd2) |-> rdata_o[7:6] == 2'b11);

  p_iid_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_iid && !raise_tx && !raise_rx && !(rd_en_i && addr_i == 3'd0 && !div_sel))
      |-> iid == 8'h01);

  p_lstat_fixed_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_en_i && addr_i == 3'd5) |-> rdata_o[6:5] == 2'b11);

  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_count <= CNT_W'(QUEUE_DEPTH));

  p_irq_cause_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(wr_en_i || rx_valid_i));
endmodule

bind serial_reg_bank serial_reg_bank_chk #(
  .QUEUE_DEPTH (QUEUE_DEPTH),
  .CNT_W       (CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .rx_valid_i (rx_valid_i),
  .rdata_o    (rdata_o),
  .tx_valid_o (tx_valid_o),
  .irq_o      (irq_o),
  .div_sel    (div_sel),
  .loop       (loop),
  .rd_iid     (rd_iid),
  .raise_tx   (raise_tx),
  .raise_rx   (raise_rx),
  .iid        (iid),
  .q_count    (q_count)
);

// File: tb/serial_reg_bank_test.sv
`timescale 1ns/1ps
module serial_reg_bank_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, rx_valid = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rx_data = '0;
  logic [7:0] rdata, tx_data;
  logic       tx_valid, irq;

  logic       s_tx_v, s_irq;
  logic [7:0] s_tx_d, s_rd;
  int         checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  serial_reg_bank uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    s_tx_v = tx_valid; s_tx_d = tx_data; s_irq = irq;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    s_rd = rdata; s_irq = irq;
  endtask

  task automatic rx(input logic [7:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
    s_irq = irq;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset values
    rd(3'd1); chk("R1 ien", s_rd, 8'h00);
    rd(3'd2); chk("R1 iid", s_rd, 8'hC1);
    rd(3'd3); chk("R1 lctl", s_rd, 8'h03);
    rd(3'd4); chk("R1 mctl", s_rd, 8'h08);
    rd(3'd5); chk("R1 lstat", s_rd, 8'h60);
    rd(3'd6); chk("R1 mstat", s_rd, 8'hB0);
    rd(3'd7); chk("R1 scr", s_rd, 8'h00);
    wr(3'd3, 8'h83);
    rd(3'd0); chk("R1 div lo", s_rd, 8'h0C);
    rd(3'd1); chk("R1 div hi", s_rd, 8'h00);

    // R2 divisor access
    wr(3'd0, 8'h34); chk("R2 no tx", {7'b0, s_tx_v}, 8'h00);
    wr(3'd1, 8'h12);
    rd(3'd0); chk("R2 div lo", s_rd, 8'h34);
    rd(3'd1); chk("R2 div hi", s_rd, 8'h12);
    wr(3'd3, 8'h03);
    rd(3'd1); chk("R2 ien untouched", s_rd, 8'h00);
    rd(3'd5); chk("R2 queue untouched", s_rd, 8'h60);

    // R3 / R13 sweeps
    for (int v = 0; v < 256; v++) begin
      wr(3'd1, 8'(v)); rd(3'd1); chk("R3 ien nibble", s_rd, 8'(v & 15));
      wr(3'd7, 8'(v)); rd(3'd7); chk("R13 scr", s_rd, 8'(v));
    end
    wr(3'd1, 8'h00);
    for (int v = 0; v < 128; v += 7) begin
      wr(3'd3, 8'(v)); rd(3'd3); chk("R13 lctl", s_rd, 8'(v));
    end
    wr(3'd3, 8'h03);
    for (int v = 0; v < 256; v += 5) begin
      wr(3'd4, 8'(v & 8'hEF)); rd(3'd4); chk("R13 mctl", s_rd, 8'(v & 8'hEF));
    end
    wr(3'd4, 8'h08);
    wr(3'd2, 8'hFF); wr(3'd5, 8'hFF); wr(3'd6, 8'h00);
    rd(3'd2); chk("R13 iid write ignored", s_rd, 8'hC1);
    rd(3'd5); chk("R13 lstat write ignored", s_rd, 8'h60);
    rd(3'd6); chk("R13 mstat write ignored", s_rd, 8'hB0);

    // R4 tx stream, no irq with ien 0
    for (int v = 0; v < 256; v++) begin
      wr(3'd0, 8'(v));
      chk("R4 tx valid", {7'b0, s_tx_v}, 8'h01);
      chk("R4 tx data", s_tx_d, 8'(v));
      chk("R14 no irq", {7'b0, s_irq}, 8'h00);
    end
    @(negedge clk); chk("R4 tx single cycle", {7'b0, tx_valid}, 8'h00);

    // R5 transmit cause
    wr(3'd1, 8'h02);
    wr(3'd0, 8'h5A); chk("R5 irq", {7'b0, s_irq}, 8'h01);
    @(negedge clk); chk("R14 irq one cycle", {7'b0, irq}, 8'h00);
    rd(3'd2); chk("R5 iid tx", s_rd, 8'hC2);
    rd(3'd2); chk("R9 iid after read", s_rd, 8'hC1);

    // R6 / R7 receive path
    wr(3'd1, 8'h00);
    for (int i = 0; i < 10; i++) begin
      rx(8'(i * 17 + 3)); chk("R14 rx no irq", {7'b0, s_irq}, 8'h00);
    end
    rd(3'd5); chk("R6 lstat ready", s_rd, 8'h61);
    for (int i = 0; i < 10; i++) begin
      rd(3'd0); chk("R7 order", s_rd, 8'(i * 17 + 3));
    end
    rd(3'd5); chk("R7 lstat empty", s_rd, 8'h60);
    rd(3'd0); chk("R7 empty reads 0", s_rd, 8'h00);

    wr(3'd1, 8'h01);
    rx(8'hC3); chk("R6 irq", {7'b0, s_irq}, 8'h01);
    rd(3'd2); chk("R6 iid rx", s_rd, 8'hC4);
    rd(3'd0); chk("R7 pop", s_rd, 8'hC3);
    rx(8'h33);
    rd(3'd0); chk("R8 pop", s_rd, 8'h33);
    rd(3'd2); chk("R8 rx cleared", s_rd, 8'hC1);

    // R8 with both causes pending
    wr(3'd1, 8'h03);
    rx(8'h11);
    wr(3'd0, 8'h22); chk("R5 irq both", {7'b0, s_irq}, 8'h01);
    rd(3'd0); chk("R8 pop both", s_rd, 8'h11);
    rd(3'd2); chk("R8 tx remains", s_rd, 8'hC2);
    rd(3'd2); chk("R9 reset", s_rd, 8'hC1);
    wr(3'd1, 8'h00);

    // R10 loopback
    wr(3'd4, 8'h10);
    wr(3'd0, 8'hA5); chk("R10 no tx", {7'b0, s_tx_v}, 8'h00);
    rx(8'h77);
    rd(3'd5); chk("R10 lstat", s_rd, 8'h61);
    rd(3'd0); chk("R10 looped byte", s_rd, 8'hA5);
    rd(3'd5); chk("R10 rx dropped", s_rd, 8'h60);

    // R11 loopback capacity
    for (int i = 0; i < 70; i++) wr(3'd0, 8'(i + 100));
    for (int i = 0; i < 64; i++) begin
      rd(3'd0); chk("R11 loop fill", s_rd, 8'(i + 100));
    end
    rd(3'd5); chk("R11 loop drained", s_rd, 8'h60);
    rd(3'd0); chk("R11 loop extra dropped", s_rd, 8'h00);

    // R12 modem status mapping
    for (int m = 0; m < 16; m++) begin
      wr(3'd4, 8'(8'h10 | m));
      rd(3'd6);
      chk("R12 loop mstat", s_rd,
          8'((((m >> 3) & 1) << 7) | (((m >> 2) & 1) << 6) | ((m & 1) << 5) | (((m >> 1) & 1) << 4)));
    end
    wr(3'd4, 8'h0F);
    rd(3'd6); chk("R12 normal mstat", s_rd, 8'hB0);

    // R11 external capacity
    wr(3'd4, 8'h08);
    for (int i = 0; i < 66; i++) rx(8'(255 - i));
    for (int i = 0; i < 64; i++) begin
      rd(3'd0); chk("R11 rx fill", s_rd, 8'(255 - i));
    end
    rd(3'd0); chk("R11 rx extra dropped", s_rd, 8'h00);

    summary();
  end
endmodule